// File: doc/BRIEF.md
# Array Reconfiguration Cache Controller

This controller sits between the fetch stage of a processor pipeline and a reconfigurable array that works as a functional unit in the execute stage. It keeps a small direct-mapped table of array configurations. Each entry is keyed by the instruction address where a translated bytecode sequence starts. Every fetch address goes through a lookup. On a hit, the controller loads the stored configuration into all array cells at once, in two beats. At the same time it collects the operands the sequence needs: one word from a static-data cache, reached through a pointer held in the entry, and one local variable from the register bank. While this happens the rest of the pipeline is stalled. The array then runs for the stored number of cycles, and the program counter is redirected to the stored resume address.

The timing follows the pipeline. The lookup happens in stage 1 and the array is in stage 4. That leaves one cycle to find the line and two cycles to load it. When an operand fetch is blocked, by a cache miss or by a busy register-bank port, extra wait cycles are inserted before execution starts. A detector unit writes new entries through a write port. A write to the entry that is in use right now is held off until that use ends.

Top module: `rcc_ctrl`

## Requirements
- R1: After reset, `stall_o`, `array_active_o`, `pc_load_o`, `cell_load_o`, `static_req_o` and `local_req_o` are all low, and `wr_ready_o` is high.
- R2: A fetch accepted at clock edge k whose address equals the full stored address of a valid entry gives two load cycles, right after edges k+1 and k+2. With no wait cycles, `array_active_o` rises right after edge k+3. In the first load cycle `cell_beat_o` is 0, and in the second it is 1.
- R3: A fetch that misses, because the entry is invalid or its stored address differs, causes no load, stall or redirect. A fetch presented in the cycle right after a miss is looked up normally.
- R4: In both load cycles every bit of `cell_load_o` is high together. Slice c of `cell_cfg_o` (HALF_W bits at offset c*HALF_W) carries bits [HALF_W-1:0] of cell c's configuration when the beat is 0, and bits [CELL_W-1:HALF_W] when the beat is 1.
- R5: `stall_o` is high from the first load cycle through the last execute cycle, and low at all other times.
- R6: `array_active_o` stays high for n cycles, where n is the stored cycle count. A stored count of 0 runs for 1 cycle.
- R7: In the cycle after the last execute cycle, `pc_load_o` is high for exactly one cycle, with `pc_target_o` equal to the stored resume address.
- R8: If the entry's static flag is set, `static_req_o` rises in the first load cycle, carries the stored pointer, and stays high until a cycle in which `static_ack_i` is high. If the flag is clear, no request is made.
- R9: If the entry's local flag is set, `local_req_o` rises in the first load cycle, carries the stored local index, and stays high until a cycle in which `local_gnt_i` is high. If the flag is clear, no request is made.
- R10: If a request is still open at the end of the second load cycle, wait cycles follow, with stall high. Execution starts in the cycle after the edge at which the last open request is acknowledged.
- R11: `wr_ready_o` is low while the controller is busy (any state other than idle) and the write index equals the index in use. A write is taken only when both `wr_valid_i` and `wr_ready_o` are high. Writes to other indices are taken at any time.
- R12: A fetch presented while a hit is being loaded, waited on, executed or redirected is ignored.
- R13: The entry index is the low log2(N_ENTRY) bits of the address. A write replaces the whole entry at that index, so afterwards the old address misses and the new address hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Fetch stage presents an address |
| fetch_addr_i | input | ADDR_W | Fetch address |
| wr_valid_i | input | 1 | Detector offers an entry |
| wr_ready_o | output | 1 | Entry write can be taken |
| wr_addr_i | input | ADDR_W | Start address of the new sequence |
| wr_cells_i | input | N_CELL*CELL_W | Configurations of all cells, cell c at c*CELL_W |
| wr_cycles_i | input | CNT_W | Execution cycle count |
| wr_resume_i | input | ADDR_W | Address to resume at |
| wr_static_en_i | input | 1 | Sequence needs a static value |
| wr_static_ptr_i | input | PTR_W | Static-data cache pointer |
| wr_local_en_i | input | 1 | Sequence needs a local variable |
| wr_local_idx_i | input | LV_W | Local variable index |
| cell_load_o | output | N_CELL | Per-cell configuration load strobe |
| cell_beat_o | output | 1 | Configuration half being loaded |
| cell_cfg_o | output | N_CELL*HALF_W | Configuration halves for all cells |
| static_req_o | output | 1 | Static value request |
| static_ptr_o | output | PTR_W | Static value pointer |
| static_ack_i | input | 1 | Static value delivered |
| local_req_o | output | 1 | Local variable request |
| local_idx_o | output | LV_W | Local variable index |
| local_gnt_i | input | 1 | Register-bank port granted |
| stall_o | output | 1 | Stall the normal pipeline |
| array_active_o | output | 1 | Array is the active functional unit |
| pc_load_o | output | 1 | Redirect the program counter |
| pc_target_o | output | ADDR_W | Redirect address |

## Verification
The hardest case to reach is a write aimed at the entry in use, arriving while a wait state stretches the reconfiguration. The write must stay held through the load, wait and execute phases and then land exactly as the controller returns to idle. The bench gets there by holding back the static acknowledge for several cycles after a hit, while it keeps a write to the same index asserted, together with a write to another index and a stray fetch. A later fetch of the old and the new address then shows at the ports whether the write landed, and when.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_LOAD0, ST_LOAD1, ST_WAIT, ST_EXEC, ST_REDIR
  } rcc_state_e;
endpackage

// File: rtl/rcc_store.sv
module rcc_store #(
  parameter int ADDR_W  = 16,
  parameter int N_ENTRY = 16,
  parameter int N_CELL  = 3,
  parameter int CELL_W  = 32,
  parameter int CNT_W   = 6,
  parameter int PTR_W   = 8,
  parameter int LV_W    = 4,
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [N_CELL*CELL_W-1:0] wr_cells_i,
  input  logic [CNT_W-1:0]         wr_cycles_i,
  input  logic [ADDR_W-1:0]        wr_resume_i,
  input  logic                     wr_static_en_i,
  input  logic [PTR_W-1:0]         wr_static_ptr_i,
  input  logic                     wr_local_en_i,
  input  logic [LV_W-1:0]          wr_local_idx_i,
  input  logic [IDX_W-1:0]         rd_idx_i,
  output logic                     rd_valid_o,
  output logic [ADDR_W-1:0]        rd_tag_o,
  output logic [N_CELL*CELL_W-1:0] rd_cells_o,
  output logic [CNT_W-1:0]         rd_cycles_o,
  output logic [ADDR_W-1:0]        rd_resume_o,
  output logic                     rd_static_en_o,
  output logic [PTR_W-1:0]         rd_static_ptr_o,
  output logic                     rd_local_en_o,
  output logic [LV_W-1:0]          rd_local_idx_o
);
  logic [IDX_W-1:0]  wr_idx;
  logic [N_ENTRY-1:0] valid_q;
  logic [ADDR_W-1:0] tag_q    [N_ENTRY];
  logic [CNT_W-1:0]  cyc_q    [N_ENTRY];
  logic [ADDR_W-1:0] res_q    [N_ENTRY];
  logic              sen_q    [N_ENTRY];
  logic [PTR_W-1:0]  sptr_q   [N_ENTRY];
  logic              len_q    [N_ENTRY];
  logic [LV_W-1:0]   lidx_q   [N_ENTRY];

  assign wr_idx = wr_addr_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx]  <= wr_addr_i;
      cyc_q[wr_idx]  <= wr_cycles_i;
      res_q[wr_idx]  <= wr_resume_i;
      sen_q[wr_idx]  <= wr_static_en_i;
      sptr_q[wr_idx] <= wr_static_ptr_i;
      len_q[wr_idx]  <= wr_local_en_i;
      lidx_q[wr_idx] <= wr_local_idx_i;
    end
  end

  // one private configuration store per cell
  for (genvar c = 0; c < N_CELL; c++) begin : g_cell
    logic [CELL_W-1:0] cfg_q [N_ENTRY];
    always_ff @(posedge clk_i) begin
      if (wr_en_i) cfg_q[wr_idx] <= wr_cells_i[c*CELL_W +: CELL_W];
    end
    assign rd_cells_o[c*CELL_W +: CELL_W] = cfg_q[rd_idx_i];
  end

  assign rd_valid_o      = valid_q[rd_idx_i];
  assign rd_tag_o        = tag_q[rd_idx_i];
  assign rd_cycles_o     = cyc_q[rd_idx_i];
  assign rd_resume_o     = res_q[rd_idx_i];
  assign rd_static_en_o  = sen_q[rd_idx_i];
  assign rd_static_ptr_o = sptr_q[rd_idx_i];
  assign rd_local_en_o   = len_q[rd_idx_i];
  assign rd_local_idx_o  = lidx_q[rd_idx_i];
endmodule

// File: rtl/rcc_operand_chan.sv
module rcc_operand_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic window_i,
  input  logic need_i,
  input  logic ack_i,
  output logic req_o,
  output logic done_o
);
  logic done_q;

  assign req_o  = window_i && need_i && !done_q;
  assign done_o = !need_i || done_q || ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                done_q <= 1'b0;
    else if (start_i)           done_q <= 1'b0;
    else if (req_o && ack_i)    done_q <= 1'b1;
  end
endmodule

// File: rtl/rcc_seq.sv
module rcc_seq
  import rcc_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fetch_valid_i,
  input  logic             hit_i,
  input  logic             ops_done_i,
  input  logic [CNT_W-1:0] cycles_i,
  output rcc_state_e       state_o,
  output logic             accept_o,
  output logic             start_o
);
  rcc_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  assign accept_o = fetch_valid_i &&
                    (state_q == ST_IDLE || (state_q == ST_LOOKUP && !hit_i));
  assign start_o  = (state_q == ST_LOOKUP) && hit_i;
  assign state_o  = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept_o) state_d = ST_LOOKUP;
      ST_LOOKUP: state_d = hit_i ? ST_LOAD0 : (accept_o ? ST_LOOKUP : ST_IDLE);
      ST_LOAD0:  state_d = ST_LOAD1;
      ST_LOAD1,
      ST_WAIT:   state_d = ops_done_i ? ST_EXEC : ST_WAIT;
      ST_EXEC:   if (cnt_q <= CNT_W'(1)) state_d = ST_REDIR;
      ST_REDIR:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d == ST_EXEC && state_q != ST_EXEC)
        cnt_q <= (cycles_i == '0) ? CNT_W'(1) : cycles_i;
      else if (state_q == ST_EXEC)
        cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/rcc_ctrl.sv
module rcc_ctrl
  import rcc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int N_ENTRY = 16,
  parameter int N_CELL  = 3,
  parameter int CELL_W  = 32,
  parameter int CNT_W   = 6,
  parameter int PTR_W   = 8,
  parameter int LV_W    = 4,
  localparam int IDX_W  = $clog2(N_ENTRY),
  localparam int HALF_W = CELL_W / 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     fetch_valid_i,
  input  logic [ADDR_W-1:0]        fetch_addr_i,
  input  logic                     wr_valid_i,
  output logic                     wr_ready_o,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [N_CELL*CELL_W-1:0] wr_cells_i,
  input  logic [CNT_W-1:0]         wr_cycles_i,
  input  logic [ADDR_W-1:0]        wr_resume_i,
  input  logic                     wr_static_en_i,
  input  logic [PTR_W-1:0]         wr_static_ptr_i,
  input  logic                     wr_local_en_i,
  input  logic [LV_W-1:0]          wr_local_idx_i,
  output logic [N_CELL-1:0]        cell_load_o,
  output logic                     cell_beat_o,
  output logic [N_CELL*HALF_W-1:0] cell_cfg_o,
  output logic                     static_req_o,
  output logic [PTR_W-1:0]         static_ptr_o,
  input  logic                     static_ack_i,
  output logic                     local_req_o,
  output logic [LV_W-1:0]          local_idx_o,
  input  logic                     local_gnt_i,
  output logic                     stall_o,
  output logic                     array_active_o,
  output logic                     pc_load_o,
  output logic [ADDR_W-1:0]        pc_target_o
);
  rcc_state_e state;
  logic accept, start, hit, ops_done, window, loading;
  logic s_done, l_done, s_en, l_en;
  logic [IDX_W-1:0]  cur_idx_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic rd_valid;
  logic [ADDR_W-1:0] rd_tag;
  logic [N_CELL*CELL_W-1:0] rd_cells;
  logic [CNT_W-1:0] rd_cycles;
  logic wr_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_idx_q  <= '0;
      cur_addr_q <= '0;
    end else if (accept) begin
      cur_idx_q  <= fetch_addr_i[IDX_W-1:0];
      cur_addr_q <= fetch_addr_i;
    end
  end

  // entry in use may not change under the sequencer
  assign wr_ready_o = !(state != ST_IDLE && wr_addr_i[IDX_W-1:0] == cur_idx_q);
  assign wr_en      = wr_valid_i && wr_ready_o;

  rcc_store #(
    .ADDR_W(ADDR_W), .N_ENTRY(N_ENTRY), .N_CELL(N_CELL), .CELL_W(CELL_W),
    .CNT_W(CNT_W), .PTR_W(PTR_W), .LV_W(LV_W)
  ) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i, .wr_cells_i, .wr_cycles_i, .wr_resume_i,
    .wr_static_en_i, .wr_static_ptr_i, .wr_local_en_i, .wr_local_idx_i,
    .rd_idx_i(cur_idx_q), .rd_valid_o(rd_valid), .rd_tag_o(rd_tag),
    .rd_cells_o(rd_cells), .rd_cycles_o(rd_cycles), .rd_resume_o(pc_target_o),
    .rd_static_en_o(s_en), .rd_static_ptr_o(static_ptr_o),
    .rd_local_en_o(l_en), .rd_local_idx_o(local_idx_o)
  );

  assign hit = rd_valid && (rd_tag == cur_addr_q);

  rcc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni, .fetch_valid_i, .hit_i(hit), .ops_done_i(ops_done),
    .cycles_i(rd_cycles), .state_o(state), .accept_o(accept), .start_o(start)
  );

  assign window = state inside {ST_LOAD0, ST_LOAD1, ST_WAIT};

  rcc_operand_chan u_static (
    .clk_i, .rst_ni, .start_i(start), .window_i(window), .need_i(s_en),
    .ack_i(static_ack_i), .req_o(static_req_o), .done_o(s_done)
  );

  rcc_operand_chan u_local (
    .clk_i, .rst_ni, .start_i(start), .window_i(window), .need_i(l_en),
    .ack_i(local_gnt_i), .req_o(local_req_o), .done_o(l_done)
  );

  assign ops_done = s_done && l_done;

  assign loading     = state inside {ST_LOAD0, ST_LOAD1};
  assign cell_beat_o = (state == ST_LOAD1);

  for (genvar c = 0; c < N_CELL; c++) begin : g_cell_out
    assign cell_load_o[c] = loading;
    assign cell_cfg_o[c*HALF_W +: HALF_W] = cell_beat_o
        ? rd_cells[c*CELL_W + HALF_W +: HALF_W]
        : rd_cells[c*CELL_W +: HALF_W];
  end

  assign stall_o        = window || (state == ST_EXEC);
  assign array_active_o = (state == ST_EXEC);
  assign pc_load_o      = (state == ST_REDIR);
endmodule

// File: rtl/rcc_ctrl_chk.sv
module rcc_ctrl_chk #(
  parameter int N_CELL = 3,
  parameter int PTR_W  = 8,
  parameter int LV_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_CELL-1:0] cell_load_o,
  input logic              cell_beat_o,
  input logic              static_req_o,
  input logic [PTR_W-1:0]  static_ptr_o,
  input logic              static_ack_i,
  input logic              local_req_o,
  input logic [LV_W-1:0]   local_idx_o,
  input logic              local_gnt_i,
  input logic              stall_o,
  input logic              array_active_o,
  input logic              pc_load_o
);
  assert_cells_together_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cell_load_o) |-> (&cell_load_o));

  assert_beat_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_load_o[0] && !cell_beat_o) |=> (cell_load_o[0] && cell_beat_o));

  assert_load_stalls_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cell_load_o || array_active_o) |-> stall_o);

  assert_exec_then_redirect_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    array_active_o |=> (array_active_o || pc_load_o));

  assert_redirect_follows_exec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> ($past(array_active_o) && !stall_o));

  assert_static_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (static_req_o && !static_ack_i) |=> (static_req_o && $stable(static_ptr_o)));

  assert_local_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (local_req_o && !local_gnt_i) |=> (local_req_o && $stable(local_idx_o)));
endmodule

bind rcc_ctrl rcc_ctrl_chk #(.N_CELL(N_CELL), .PTR_W(PTR_W), .LV_W(LV_W)) u_chk (.*);

// File: tb/sim_rcc_ctrl.sv
module sim_rcc_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fv = 1'b0; logic [15:0] fa = '0;
  logic wv = 1'b0, wrdy; logic [15:0] wa = '0;
  logic [95:0] wc = '0; logic [5:0] wcy = '0; logic [15:0] wres = '0;
  logic wsen = 1'b0; logic [7:0] wsp = '0; logic wlen = 1'b0; logic [3:0] wli = '0;
  logic [2:0] cl; logic cb; logic [47:0] ccfg;
  logic sreq, sack = 1'b0; logic [7:0] sptr;
  logic lreq, lgnt = 1'b0; logic [3:0] lidx;
  logic stall, act, pcl; logic [15:0] pct;

  always #(CLK_PERIOD/2) clk = ~clk;

  rcc_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .fetch_valid_i(fv), .fetch_addr_i(fa),
    .wr_valid_i(wv), .wr_ready_o(wrdy), .wr_addr_i(wa), .wr_cells_i(wc),
    .wr_cycles_i(wcy), .wr_resume_i(wres), .wr_static_en_i(wsen),
    .wr_static_ptr_i(wsp), .wr_local_en_i(wlen), .wr_local_idx_i(wli),
    .cell_load_o(cl), .cell_beat_o(cb), .cell_cfg_o(ccfg),
    .static_req_o(sreq), .static_ptr_o(sptr), .static_ack_i(sack),
    .local_req_o(lreq), .local_idx_o(lidx), .local_gnt_i(lgnt),
    .stall_o(stall), .array_active_o(act), .pc_load_o(pcl), .pc_target_o(pct)
  );

  int n_run = 0, n_fail = 0;
  string scen = "R1";

  // reference model: 0 idle 1 lookup 2 load0 3 load1 4 wait 5 exec 6 redirect
  int ms = 0, m_idx = 0, m_cnt = 0;
  logic [15:0] m_addr = '0;
  bit m_sdone = 0, m_ldone = 0;
  bit          m_v   [16];
  logic [15:0] m_tag [16];
  logic [95:0] m_cel [16];
  logic [5:0]  m_cyc [16];
  logic [15:0] m_res [16];
  bit          m_sen [16];
  logic [7:0]  m_sp  [16];
  bit          m_len [16];
  logic [3:0]  m_li  [16];

  task automatic chk(string tag, string name, logic [63:0] a, logic [63:0] e);
    n_run++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s/%s %s: actual %0h expected %0h at %0t", tag, scen, name, a, e, $time);
    end
  endtask

  function automatic bit m_hit();
    return ms == 1 && m_v[m_idx] && m_tag[m_idx] == m_addr;
  endfunction

  task automatic compare();
    bit ld = (ms == 2 || ms == 3);
    bit win = (ms >= 2 && ms <= 4);
    bit esr = win && m_sen[m_idx] && !m_sdone;
    bit elr = win && m_len[m_idx] && !m_ldone;
    logic [47:0] ecfg;
    for (int c = 0; c < 3; c++)
      ecfg[c*16 +: 16] = m_cel[m_idx][c*32 + ((ms == 3) ? 16 : 0) +: 16];
    chk("R5", "stall", stall, (ms >= 2 && ms <= 5));
    chk("R6", "active", act, (ms == 5));
    chk("R7", "pc_load", pcl, (ms == 6));
    if (ms == 6) chk("R7", "pc_target", pct, m_res[m_idx]);
    chk("R2", "cell_load", cl, ld ? 3'b111 : 3'b000);
    if (ld) begin
      chk("R2", "beat", cb, (ms == 3));
      chk("R4", "cfg", ccfg, ecfg);
    end
    chk("R8", "static_req", sreq, esr);
    if (esr) chk("R8", "static_ptr", sptr, m_sp[m_idx]);
    chk("R9", "local_req", lreq, elr);
    if (elr) chk("R9", "local_idx", lidx, m_li[m_idx]);
    chk("R11", "wr_ready", wrdy, !(ms != 0 && wa[3:0] == m_idx[3:0]));
  endtask

  task automatic step_model();
    bit h = m_hit();
    bit acc = fv && (ms == 0 || (ms == 1 && !h));
    bit win = (ms >= 2 && ms <= 4);
    bit esr = win && m_sen[m_idx] && !m_sdone;
    bit elr = win && m_len[m_idx] && !m_ldone;
    bit sdn = !m_sen[m_idx] || m_sdone || sack;
    bit ldn = !m_len[m_idx] || m_ldone || lgnt;
    bit rdy = !(ms != 0 && wa[3:0] == m_idx[3:0]);
    int old = ms;
    case (old)
      0: ms = acc ? 1 : 0;
      1: if (h) begin ms = 2; m_sdone = 0; m_ldone = 0; end
         else ms = acc ? 1 : 0;
      2: ms = 3;
      3, 4: if (sdn && ldn) begin
              ms = 5; m_cnt = (m_cyc[m_idx] == 0) ? 1 : int'(m_cyc[m_idx]);
            end else ms = 4;
      5: if (m_cnt <= 1) ms = 6; else m_cnt--;
      default: ms = 0;
    endcase
    if (acc) begin m_idx = int'(fa[3:0]); m_addr = fa; end
    if (esr && sack) m_sdone = 1;
    if (elr && lgnt) m_ldone = 1;
    if (wv && rdy) begin
      m_v[wa[3:0]] = 1; m_tag[wa[3:0]] = wa; m_cel[wa[3:0]] = wc;
      m_cyc[wa[3:0]] = wcy; m_res[wa[3:0]] = wres; m_sen[wa[3:0]] = wsen;
      m_sp[wa[3:0]] = wsp; m_len[wa[3:0]] = wlen; m_li[wa[3:0]] = wli;
    end
  endtask

  // one clock: drive after the falling edge, check, then advance the model
  task automatic cyc(bit f, logic [15:0] a, bit w, bit s, bit l);
    fv = f; fa = a; wv = w; sack = s; lgnt = l;
    #1;
    compare();
    @(posedge clk);
    step_model();
    @(negedge clk);
  endtask

  task automatic set_entry(logic [15:0] a, logic [7:0] seed, logic [5:0] cy,
                           logic [15:0] r, bit se, logic [7:0] sp, bit le, logic [3:0] li);
    wa = a; wcy = cy; wres = r; wsen = se; wsp = sp; wlen = le; wli = li;
    wc = {8'hC0, seed, 16'h3A5C ^ {seed, seed}, 8'hB0, seed, 16'h6E21 + {8'h0, seed},
          8'hA0, seed, 16'h1F0F - {8'h0, seed}};
  endtask

  task automatic idle(int n, bit s = 1, bit l = 1);
    for (int i = 0; i < n; i++) cyc(0, 16'h0, 0, s, l);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_v[i] = 0; m_tag[i] = '0; m_cel[i] = '0; m_cyc[i] = '0; m_res[i] = '0;
      m_sen[i] = 0; m_sp[i] = '0; m_len[i] = 0; m_li[i] = '0;
    end
    @(negedge clk); @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", "stall", stall, 0); chk("R1", "active", act, 0);
    chk("R1", "pc_load", pcl, 0); chk("R1", "cell_load", cl, 0);
    chk("R1", "sreq", sreq, 0); chk("R1", "lreq", lreq, 0);
    chk("R1", "wr_ready", wrdy, 1);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    scen = "R13";
    set_entry(16'h1235, 8'h11, 6'd3, 16'h1240, 1, 8'h2A, 1, 4'h7);
    cyc(0, 16'h0, 1, 1, 1);
    set_entry(16'h0402, 8'h22, 6'd0, 16'h0410, 0, 8'h00, 0, 4'h0);
    cyc(0, 16'h0, 1, 1, 1);
    idle(1);

    scen = "R6";  // zero count, no operand fetch
    cyc(1, 16'h0402, 0, 1, 1); idle(7);

    scen = "R2";  // operands delivered at once
    cyc(1, 16'h1235, 0, 1, 1); idle(9);

    scen = "R10"; // static blocked for four cycles, local port busy two
    cyc(1, 16'h1235, 0, 0, 0);
    cyc(0, 16'h0, 0, 0, 0); cyc(0, 16'h0, 0, 0, 0);
    cyc(0, 16'h0, 0, 0, 1); cyc(0, 16'h0, 0, 0, 0);
    idle(10);

    scen = "R3";  // same index, other address, then back-to-back hit
    cyc(1, 16'h2235, 0, 1, 1); cyc(1, 16'h0402, 0, 1, 1); idle(7);
    cyc(1, 16'h0007, 0, 1, 1); idle(4);

    scen = "R11"; // writes during a stretched hit on index 5, plus stray fetch
    cyc(1, 16'h1235, 0, 0, 1);
    set_entry(16'h0015, 8'h33, 6'd2, 16'h0020, 0, 8'h00, 1, 4'h3);
    for (int i = 0; i < 6; i++) cyc(0, 16'h0, 1, 0, 1);
    scen = "R12";
    cyc(1, 16'h0402, 1, 1, 1);
    for (int i = 0; i < 6; i++) cyc(0, 16'h0, 1, 1, 1);
    set_entry(16'h0409, 8'h44, 6'd1, 16'h0500, 1, 8'h99, 0, 4'h0);
    cyc(0, 16'h0, 1, 1, 1);
    idle(3);

    scen = "R13"; // old address misses, new ones hit
    cyc(1, 16'h1235, 0, 1, 1); idle(3);
    cyc(1, 16'h0015, 0, 1, 1); idle(8);
    cyc(1, 16'h0409, 0, 1, 1); idle(7);
    set_entry(16'h0812, 8'h55, 6'd4, 16'h0830, 1, 8'h12, 1, 4'hE);
    cyc(0, 16'h0, 1, 1, 1);
    cyc(1, 16'h0402, 0, 1, 1); idle(3);
    scen = "R8";
    cyc(1, 16'h0812, 0, 0, 1); cyc(0, 16'h0, 0, 0, 1);
    idle(12);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule